// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, plus the column and row of the pixel being shown. Each line and each frame is made of five phases in a fixed order: a reference phase, the sync pulse, the back porch, the active region and the front porch. The horizontal phases move once per pixel-clock enable. The vertical phases move once per completed line.

Timing comes from five 32-bit configuration words. Each word carries its horizontal value in the low half and its vertical value in the high half. Software programs the reference phase to 1 and takes that one count out of the panel's front porch, so line and frame lengths match the panel data sheet. The words are copied into shadow registers on the first clock after reset and again on the clock that closes each frame. A write made in the middle of a frame therefore never tears the picture. Coordinates are 16 bits wide, which covers panels up to 1366 × 768 and beyond.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line runs through the reference, sync, back-porch, active and front-porch phases in that order, so its length in enabled pixel clocks is ref + sync + back + width + front. A frame is built the same way from lines.
- R2: In each timing word, bits [15:0] hold the horizontal value and bits [31:16] hold the vertical value. In the active-size word, bits [15:0] hold the width and bits [31:16] hold the height.
- R3: The sync output is at its active level for exactly the programmed sync width: pixels for the horizontal sync, lines for the vertical sync.
- R4: Data enable is high only when both directions are in their active phase. Each enabled run lasts the programmed width and begins exactly back-porch pixels after the horizontal sync ends. A frame holds height such runs.
- R5: During data enable, x steps from 0 to width-1 and y holds the row, from 0 to height-1. Outside the active phase of their own direction, x and y read 0.
- R6: A polarity input of 0 makes its sync active-high. A polarity input of 1 inverts that sync output, so it idles high and pulses low.
- R7: While the pixel-clock enable is low, x, y, data enable and both syncs hold their values. The next enabled clock resumes where they stopped.
- R8: Words written during a frame take effect only from the first pixel of the following frame. The current frame finishes with the old values.
- R9: A phase programmed to zero length lasts one count.
- R10: While reset is held, data enable, x and y are 0, and each sync shows its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel per cycle where high |
| cfg_ref_sync | input | 32 | Reference-phase length, vertical[31:16], horizontal[15:0] |
| cfg_sync_w | input | 32 | Sync width, vertical[31:16], horizontal[15:0] |
| cfg_back_porch | input | 32 | Back porch, vertical[31:16], horizontal[15:0] |
| cfg_front_porch | input | 32 | Front porch, vertical[31:16], horizontal[15:0] |
| cfg_active | input | 32 | Height[31:16], width[15:0] |
| hsync_inv | input | 1 | 1 inverts the horizontal sync |
| vsync_inv | input | 1 | 1 inverts the vertical sync |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| x | output | 16 | Column within the active line |
| y | output | 16 | Row within the active frame |

## Verification
All outputs are decoded from the phase counters. Each one therefore shows the result of an enabled clock one edge later, and the polarity inputs act at once. The shadow copy of the configuration is taken on the first clock after reset and on the edge that ends a frame, so the first pixel after that edge already follows the new values. The bench drives inputs and samples outputs at the falling edge, one half-period after the register update. It measures each phase length by counting the samples between output transitions, so no check depends on knowing a specific absolute cycle.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int FW = 16;   // field width of one packed half word
  localparam int NAX = 2;   // axes: 0 horizontal, 1 vertical

  typedef enum logic [2:0] {
    PH_REF   = 3'd0,
    PH_SYNC  = 3'd1,
    PH_BACK  = 3'd2,
    PH_ACT   = 3'd3,
    PH_FRONT = 3'd4
  } phase_e;

  typedef struct packed {
    logic [FW-1:0] ref_len;
    logic [FW-1:0] sync_len;
    logic [FW-1:0] back_len;
    logic [FW-1:0] act_len;
    logic [FW-1:0] front_len;
  } axis_cfg_t;

  // Length of one phase in counts; zero is stretched to one.
  function automatic logic [FW-1:0] seg_len(input axis_cfg_t c, input phase_e p);
    logic [FW-1:0] raw;
    case (p)
      PH_REF:   raw = c.ref_len;
      PH_SYNC:  raw = c.sync_len;
      PH_BACK:  raw = c.back_len;
      PH_ACT:   raw = c.act_len;
      default:  raw = c.front_len;
    endcase
    return (raw == '0) ? FW'(1) : raw;
  endfunction

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_REF:  return PH_SYNC;
      PH_SYNC: return PH_BACK;
      PH_BACK: return PH_ACT;
      PH_ACT:  return PH_FRONT;
      default: return PH_REF;
    endcase
  endfunction
endpackage

// File: rtl/lcdt_cfg_shadow.sv
module lcdt_cfg_shadow
  import lcdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic [31:0] w_ref,
  input  logic [31:0] w_sync,
  input  logic [31:0] w_back,
  input  logic [31:0] w_front,
  input  logic [31:0] w_act,
  output axis_cfg_t h_cfg,
  output axis_cfg_t v_cfg
);
  axis_cfg_t nxt [NAX];
  axis_cfg_t shd [NAX];

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    always_comb begin
      nxt[a].ref_len   = w_ref  [FW*a +: FW];
      nxt[a].sync_len  = w_sync [FW*a +: FW];
      nxt[a].back_len  = w_back [FW*a +: FW];
      nxt[a].act_len   = w_act  [FW*a +: FW];
      nxt[a].front_len = w_front[FW*a +: FW];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    shd[a] <= '0;
      else if (load) shd[a] <= nxt[a];
    end
  end

  assign h_cfg = shd[0];
  assign v_cfg = shd[1];
endmodule

// File: rtl/lcdt_axis_seq.sv
module lcdt_axis_seq
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  axis_cfg_t     cfg,
  output phase_e        phase,
  output logic [FW-1:0] cnt,
  output logic          seg_end
);
  logic [FW-1:0] len;

  assign len     = seg_len(cfg, phase);
  assign seg_end = step && (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_REF;
      cnt   <= '0;
    end else if (step) begin
      if (seg_end) begin
        phase <= next_phase(phase);
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [31:0]   cfg_ref_sync,
  input  logic [31:0]   cfg_sync_w,
  input  logic [31:0]   cfg_back_porch,
  input  logic [31:0]   cfg_front_porch,
  input  logic [31:0]   cfg_active,
  input  logic          hsync_inv,
  input  logic          vsync_inv,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [FW-1:0] x,
  output logic [FW-1:0] y
);
  logic          load_q;     // first cycle after reset: capture config
  logic          run;        // a pixel advances this cycle
  logic          reload;     // shadow registers capture this cycle
  axis_cfg_t     h_cfg, v_cfg;
  phase_e        h_phase, v_phase;
  logic [FW-1:0] h_cnt, v_cnt;
  logic          h_end, v_end;
  logic          h_wrap, v_wrap, h_act_end;

  always_ff @(posedge clk) begin
    if (!rst_n) load_q <= 1'b1;
    else        load_q <= 1'b0;
  end

  assign run       = pix_en && !load_q;
  assign h_wrap    = h_end && (h_phase == PH_FRONT);
  assign h_act_end = h_end && (h_phase == PH_ACT);
  assign v_wrap    = v_end && (v_phase == PH_FRONT);
  assign reload    = load_q || v_wrap;

  lcdt_cfg_shadow u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (reload),
    .w_ref   (cfg_ref_sync),
    .w_sync  (cfg_sync_w),
    .w_back  (cfg_back_porch),
    .w_front (cfg_front_porch),
    .w_act   (cfg_active),
    .h_cfg   (h_cfg),
    .v_cfg   (v_cfg)
  );

  lcdt_axis_seq u_hseq (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (run),
    .cfg     (h_cfg),
    .phase   (h_phase),
    .cnt     (h_cnt),
    .seg_end (h_end)
  );

  lcdt_axis_seq u_vseq (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (h_wrap),
    .cfg     (v_cfg),
    .phase   (v_phase),
    .cnt     (v_cnt),
    .seg_end (v_end)
  );

  always_comb begin
    hsync = (h_phase == PH_SYNC) ^ hsync_inv;
    vsync = (v_phase == PH_SYNC) ^ vsync_inv;
    de    = (h_phase == PH_ACT) && (v_phase == PH_ACT);
    x     = (h_phase == PH_ACT) ? h_cnt : '0;
    y     = (v_phase == PH_ACT) ? v_cnt : '0;
  end
endmodule

// File: rtl/lcdt_timing_checker.sv
module lcdt_timing_checker
  import lcdt_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          de,
  input logic [FW-1:0] x,
  input logic [FW-1:0] y,
  input phase_e        h_phase,
  input phase_e        v_phase,
  input logic          h_wrap,
  input logic          h_act_end,
  input logic          run,
  input logic          reload,
  input axis_cfg_t     h_cfg,
  input axis_cfg_t     v_cfg
);
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(x) && $stable(y) && $stable(de)));

  assert_x_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (de && pix_en && !h_act_end) |=> (x == FW'($past(x) + 1'b1)));

  assert_ref_one_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_phase == PH_REF && run) |=> (h_phase == PH_SYNC));

  assert_de_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> ((x < seg_len(h_cfg, PH_ACT)) && (y < seg_len(v_cfg, PH_ACT))));

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> ($stable(h_cfg) && $stable(v_cfg)));

  assert_vphase_on_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> $stable(v_phase));
endmodule

bind lcd_timing_gen lcdt_timing_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_en    (pix_en),
  .de        (de),
  .x         (x),
  .y         (y),
  .h_phase   (h_phase),
  .v_phase   (v_phase),
  .h_wrap    (h_wrap),
  .h_act_end (h_act_end),
  .run       (run),
  .reload    (reload),
  .h_cfg     (h_cfg),
  .v_cfg     (v_cfg)
);

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // columns: hsync, hback, hwidth, hfront, expected line length, expected sync width
  localparam int VEC [NV][6] = '{
    '{3, 2,  8, 4, 18, 3},
    '{1, 1,  4, 1,  8, 1},
    '{5, 3, 16, 7, 32, 5},
    '{0, 2,  6, 3, 13, 1}
  };
  localparam int VS = 2, VB = 1, VH = 3, VF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  logic [31:0] cfg_ref_sync, cfg_sync_w, cfg_back_porch, cfg_front_porch, cfg_active;
  logic hsync_inv = 1'b0, vsync_inv = 1'b0;
  logic hsync, vsync, de;
  logic [15:0] x, y;

  int n_checks = 0;
  int n_errs = 0;
  int m_period, m_hsw, m_gap, m_dew, m_x0, m_xl, m_delines, m_vsw, m_ymax;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .cfg_ref_sync(cfg_ref_sync), .cfg_sync_w(cfg_sync_w),
    .cfg_back_porch(cfg_back_porch), .cfg_front_porch(cfg_front_porch),
    .cfg_active(cfg_active), .hsync_inv(hsync_inv), .vsync_inv(vsync_inv),
    .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int hs, input int hb, input int hw, input int hf);
    cfg_ref_sync    = {16'd1, 16'd1};
    cfg_sync_w      = {16'(VS), 16'(hs)};
    cfg_back_porch  = {16'(VB), 16'(hb)};
    cfg_front_porch = {16'(VF), 16'(hf)};
    cfg_active      = {16'(VH), 16'(hw)};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pix_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; pix_en = 1'b1;
  endtask

  // Measure one complete frame, from one vsync start to the next.
  task automatic measure(input logic hp, input logic vp);
    logic phs = 1'b0, pde = 1'b0, pvs = 1'b0;
    int vs_rises = 0, hs_rises = 0, de_rises = 0, t1 = 0, t_fall = 0;
    m_period = -1; m_hsw = 0; m_gap = -1; m_dew = 0; m_x0 = -1; m_xl = -1;
    m_delines = 0; m_vsw = 0; m_ymax = -1;
    for (int t = 0; t < 4000 && vs_rises < 2; t++) begin
      @(negedge clk);
      begin
        logic hs_a, vs_a;
        hs_a = hsync ^ hp;
        vs_a = vsync ^ vp;
        if (vs_a && !pvs) vs_rises++;
        if (vs_rises == 1) begin
          if (hs_a && !phs) begin
            hs_rises++;
            if (hs_rises == 1) t1 = t;
            if (hs_rises == 2) m_period = t - t1;
            if (vs_a) m_vsw++;
          end
          if (hs_a && hs_rises == 1) m_hsw++;
          if (!hs_a && phs) t_fall = t;
          if (de && !pde) begin
            de_rises++;
            if (de_rises == 1) begin m_gap = t - t_fall; m_x0 = int'(x); end
          end
          if (de && de_rises == 1) begin m_dew++; m_xl = int'(x); end
          if (de && int'(y) > m_ymax) m_ymax = int'(y);
        end
        phs = hs_a; pvs = vs_a; pde = de;
      end
    end
    m_delines = de_rises;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_errs++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin : main
    set_cfg(3, 2, 8, 4);
    repeat (3) @(negedge clk);
    // R10: reset state with both polarities 0
    check("R10 hsync in reset", int'(hsync), 0);
    check("R10 vsync in reset", int'(vsync), 0);
    check("R10 de in reset", int'(de), 0);
    check("R10 x in reset", int'(x), 0);
    check("R10 y in reset", int'(y), 0);

    // Vector table: horizontal shapes, fixed vertical shape
    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      do_reset();
      measure(1'b0, 1'b0);
      check("R1 R2 line length", m_period, VEC[v][4]);
      check("R3 R9 hsync width", m_hsw, VEC[v][5]);
      check("R4 back porch gap", m_gap, VEC[v][1]);
      check("R4 de run length", m_dew, VEC[v][2]);
      check("R5 first x", m_x0, 0);
      check("R5 last x", m_xl, VEC[v][2] - 1);
      check("R4 de lines per frame", m_delines, VH);
      check("R2 R3 vsync width in lines", m_vsw, VS);
      check("R5 last y", m_ymax, VH - 1);
    end

    // R6: inverted polarity
    set_cfg(3, 2, 8, 4);
    hsync_inv = 1'b1; vsync_inv = 1'b1;
    do_reset();
    measure(1'b1, 1'b1);
    check("R6 inverted line length", m_period, 18);
    check("R6 inverted hsync width", m_hsw, 3);
    check("R6 inverted vsync width", m_vsw, VS);
    while (!de) @(negedge clk);
    check("R6 hsync idle high", int'(hsync), 1);
    check("R6 vsync idle high", int'(vsync), 1);
    hsync_inv = 1'b0; vsync_inv = 1'b0;

    // R7: freeze with pix_en low
    do_reset();
    @(negedge clk);
    while (!(de && x == 16'd2)) @(negedge clk);
    begin
      int fy;
      logic fh, fv;
      fy = int'(y); fh = hsync; fv = vsync;
      pix_en = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        check("R7 x frozen", int'(x), 2);
        check("R7 de frozen", int'(de), 1);
        if (k == 5) begin
          check("R7 y frozen", int'(y), fy);
          check("R7 hsync frozen", int'(hsync), int'(fh));
          check("R7 vsync frozen", int'(vsync), int'(fv));
        end
      end
      pix_en = 1'b1;
      @(negedge clk);
      check("R7 resume x", int'(x), 3);
    end

    // R8: width change mid-frame waits for next frame
    while (de) @(negedge clk);
    while (!de) @(negedge clk);
    cfg_active = {16'(VH), 16'd5};
    begin
      int n = 0;
      while (de) begin n++; @(negedge clk); end
      check("R8 old width kept in frame", n, 8);
      while (vsync) @(negedge clk);
      while (!vsync) @(negedge clk);
      while (!de) @(negedge clk);
      n = 0;
      while (de) begin n++; @(negedge clk); end
      check("R8 new width next frame", n, 5);
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule